// File: doc/BRIEF.md
# DRAM Rank Power-State Controller

This block decides how deeply each DRAM rank sleeps. It reads an encoded package power state, the pending-request flag of every rank, a refresh request, and the graphics configuration and activity flags. From these it drives a clock-enable (CKE) per rank. It also issues precharge-all, refresh, self-refresh entry and self-refresh exit commands to an abstract command issuer. A separate flag marks that memory is powered off.

In the shallow package states, every rank goes to sleep on its own once it has been quiet for a programmable number of cycles. In the deep package states the whole memory may be put into self-refresh. Whether that is allowed depends on the graphics configuration. The sleep style is selectable: active power-down keeps rows open, while precharge power-down closes all pages with a command before CKE drops. A refresh wakes every rank first. When the refresh is done, the idle ranks are put back to sleep together.

Commands leave on a valid/ready channel. Once `cmd_valid` rises, `cmd_op` and `cmd_mask` stay constant until a cycle in which `cmd_ready` is also high. That cycle is the handshake. Back-pressure may last any number of cycles, and the controller makes no other state decision while it waits.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: After reset every CKE is high, `cmd_valid` is low and `mem_off` is low.
- R2: In package states 0, 1 and 2, a rank with no pending request drops CKE at the (L+1)-th clock edge after its request flag fell, where L is `idle_limit`. Each rank is handled on its own.
- R3: A request on a rank whose CKE is low raises that rank's CKE at the next clock edge.
- R4: When `cfg_ext_gfx`=1 and the package state is 3, 4 or 5, a SR_ENTER command (op 2, mask all ones) is issued once no rank has a pending request. While any request is pending, no command is issued and per-rank power-down continues. While in self-refresh, a new request causes SR_EXIT (op 3).
- R5: When `cfg_ext_gfx`=0 and the package state is 3, 4 or 5, SR_ENTER is issued only when `gfx_idle`=1 and `disp_pending`=0, whatever the rank requests are.
- R6: Package state 6 keeps memory in self-refresh with all CKE low and no command. Package state 7 sets `mem_off` and drops all CKE. Leaving state 7 clears `mem_off` and raises all CKE at the next edge.
- R7: With `cfg_pre_pd`=0, a rank's CKE drops without any command.
- R8: With `cfg_pre_pd`=1, idle ranks are first closed by a PRECHARGE_ALL command (op 0) whose mask lists them. Their CKE stays high until the handshake and drops at the handshake edge.
- R9: On `refresh_req` in a shallow state, all CKE rise at the next edge and a REFRESH command (op 1, mask all ones) is offered. After its handshake, `refresh_fire` is high for one cycle and CKE equals the pending flags.
- R10: `rank_ready` is high for a rank only while its CKE is high and no command is in progress. It stays low through a SR_EXIT until that command's handshake.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_mask` hold their values on the next cycle.
- R12: A package-state change during a handshake wait does not abort the command. It takes effect after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkg_state | input | 3 | Package state: 0,1,2 shallow; 3,4,5 deep; 6 suspend; 7 off |
| idle_limit | input | CNT_W | Quiet cycles before a rank counts as idle |
| cfg_ext_gfx | input | 1 | 1 = external graphics, 0 = integrated graphics |
| gfx_idle | input | 1 | Integrated graphics engine idle |
| disp_pending | input | 1 | Display requests outstanding |
| cfg_pre_pd | input | 1 | 1 = precharge power-down, 0 = active power-down |
| rank_pending | input | NUM_RANKS | Per-rank request pending |
| refresh_req | input | 1 | Refresh wanted (held until `refresh_fire`) |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted by the issuer |
| cmd_op | output | 2 | 0 precharge-all, 1 refresh, 2 SR enter, 3 SR exit |
| cmd_mask | output | NUM_RANKS | Ranks the command applies to |
| cke | output | NUM_RANKS | Per-rank clock enable |
| rank_ready | output | NUM_RANKS | Rank may accept normal commands |
| refresh_fire | output | 1 | One-cycle strobe after a refresh handshake |
| mem_off | output | 1 | Memory powered off, contents lost |

## Verification
The per-rank sleep path is tried in three ways. Staggered request drops on two ranks show that the idle counters run independently. A shortened idle limit shows that the threshold is taken from the input. A refresh issued while every rank sleeps shows the forced wake and the return to sleep. The deep-state policy is tried by holding, in turn, a rank request, a busy graphics engine and an outstanding display request. With external graphics the rank request blocks self-refresh. With integrated graphics only the graphics flags do, and a pending rank request does not. A package change made during a stalled SR_ENTER shows that the command completes and that the exit comes afterwards. A scoreboard compares every command handshake with the expected opcode and mask.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam logic [2:0] PS_C0  = 3'd0;
  localparam logic [2:0] PS_C1  = 3'd1;
  localparam logic [2:0] PS_C1E = 3'd2;
  localparam logic [2:0] PS_C3  = 3'd3;
  localparam logic [2:0] PS_C6  = 3'd4;
  localparam logic [2:0] PS_C7  = 3'd5;
  localparam logic [2:0] PS_S3  = 3'd6;
  localparam logic [2:0] PS_S4  = 3'd7;

  typedef enum logic [1:0] {
    OP_PREALL   = 2'd0,
    OP_REFRESH  = 2'd1,
    OP_SR_ENTER = 2'd2,
    OP_SR_EXIT  = 2'd3
  } cmd_op_t;

  typedef enum logic [2:0] {
    ST_RUN, ST_PREALL, ST_REF, ST_SR_ENTER, ST_SR, ST_SR_EXIT, ST_OFF
  } pwr_state_t;
endpackage

// File: rtl/rpc_idle_track.sv
module rpc_idle_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend,
  input  logic [CNT_W-1:0] limit,
  input  logic             clr,
  input  logic             sat,
  output logic             idle
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || pend || clr) cnt_q <= '0;
    else if (sat)              cnt_q <= limit;
    else if (cnt_q < limit)    cnt_q <= cnt_q + 1'b1;
  end

  assign idle = !pend && (cnt_q >= limit);
endmodule

// File: rtl/rpc_policy.sv
module rpc_policy import rpc_pkg::*; #(
  parameter int NUM_RANKS = 2
) (
  input  logic [2:0]           pkg_state,
  input  logic [NUM_RANKS-1:0] rank_pending,
  input  logic                 cfg_ext_gfx,
  input  logic                 gfx_idle,
  input  logic                 disp_pending,
  output logic                 want_sr,
  output logic                 want_off
);
  logic deep, quiet;

  always_comb begin
    deep     = (pkg_state == PS_C3) || (pkg_state == PS_C6) || (pkg_state == PS_C7);
    quiet    = cfg_ext_gfx ? ~|rank_pending : (gfx_idle && !disp_pending);
    want_off = (pkg_state == PS_S4);
    want_sr  = (pkg_state == PS_S3) || (deep && quiet);
  end
endmodule

// File: rtl/rank_pwr_ctrl.sv
module rank_pwr_ctrl import rpc_pkg::*; #(
  parameter int NUM_RANKS = 2,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           pkg_state,
  input  logic [CNT_W-1:0]     idle_limit,
  input  logic                 cfg_ext_gfx,
  input  logic                 gfx_idle,
  input  logic                 disp_pending,
  input  logic                 cfg_pre_pd,
  input  logic [NUM_RANKS-1:0] rank_pending,
  input  logic                 refresh_req,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [1:0]           cmd_op,
  output logic [NUM_RANKS-1:0] cmd_mask,
  output logic [NUM_RANKS-1:0] cke,
  output logic [NUM_RANKS-1:0] rank_ready,
  output logic                 refresh_fire,
  output logic                 mem_off
);
  localparam logic [NUM_RANKS-1:0] ALL_RANKS = {NUM_RANKS{1'b1}};

  pwr_state_t             st_q;
  logic [NUM_RANKS-1:0]   cke_q, pd_mask_q, idle, close_set;
  logic                   want_sr, want_off, fire_q, trk_clr, trk_sat;

  rpc_policy #(.NUM_RANKS(NUM_RANKS)) u_policy (
    .pkg_state(pkg_state), .rank_pending(rank_pending), .cfg_ext_gfx(cfg_ext_gfx),
    .gfx_idle(gfx_idle), .disp_pending(disp_pending),
    .want_sr(want_sr), .want_off(want_off)
  );

  assign trk_clr = ((st_q == ST_SR_EXIT) && cmd_ready) || ((st_q == ST_OFF) && !want_off);
  assign trk_sat = (st_q == ST_REF) && cmd_ready;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    rpc_idle_track #(.CNT_W(CNT_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .pend(rank_pending[r]), .limit(idle_limit),
      .clr(trk_clr), .sat(trk_sat), .idle(idle[r])
    );
  end

  assign close_set = idle & cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_RUN;
      cke_q     <= ALL_RANKS;
      pd_mask_q <= '0;
      fire_q    <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      unique case (st_q)
        ST_RUN: begin
          if (want_off) begin
            st_q  <= ST_OFF;
            cke_q <= '0;
          end else if (want_sr) begin
            st_q <= ST_SR_ENTER;
          end else if (refresh_req) begin
            st_q  <= ST_REF;
            cke_q <= ALL_RANKS;
          end else if (cfg_pre_pd) begin
            cke_q <= cke_q | rank_pending;
            if (|close_set) begin
              pd_mask_q <= close_set;
              st_q      <= ST_PREALL;
            end
          end else begin
            cke_q <= ~idle;
          end
        end
        ST_PREALL: begin
          if (cmd_ready) begin
            cke_q <= (cke_q | rank_pending) & ~(pd_mask_q & ~rank_pending);
            st_q  <= ST_RUN;
          end else begin
            cke_q <= cke_q | rank_pending;
          end
        end
        ST_REF: begin
          if (cmd_ready) begin
            cke_q  <= rank_pending;
            fire_q <= 1'b1;
            st_q   <= ST_RUN;
          end
        end
        ST_SR_ENTER: begin
          if (cmd_ready) begin
            cke_q <= '0;
            st_q  <= ST_SR;
          end
        end
        ST_SR: begin
          if (want_off)     st_q <= ST_OFF;
          else if (!want_sr) st_q <= ST_SR_EXIT;
        end
        ST_SR_EXIT: begin
          if (cmd_ready) begin
            cke_q <= ALL_RANKS;
            st_q  <= ST_RUN;
          end
        end
        ST_OFF: begin
          if (!want_off) begin
            cke_q <= ALL_RANKS;
            st_q  <= ST_RUN;
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_PREALL;
    cmd_mask  = ALL_RANKS;
    unique case (st_q)
      ST_PREALL:   begin cmd_valid = 1'b1; cmd_op = OP_PREALL; cmd_mask = pd_mask_q; end
      ST_REF:      begin cmd_valid = 1'b1; cmd_op = OP_REFRESH;  end
      ST_SR_ENTER: begin cmd_valid = 1'b1; cmd_op = OP_SR_ENTER; end
      ST_SR_EXIT:  begin cmd_valid = 1'b1; cmd_op = OP_SR_EXIT;  end
      default:     ;
    endcase
  end

  assign cke          = cke_q;
  assign rank_ready   = (st_q == ST_RUN) ? cke_q : '0;
  assign refresh_fire = fire_q;
  assign mem_off      = (st_q == ST_OFF);
endmodule

// File: rtl/rpc_checks.sv
module rpc_checks #(
  parameter int NUM_RANKS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [1:0]           cmd_op,
  input logic [NUM_RANKS-1:0] cmd_mask,
  input logic [NUM_RANKS-1:0] cke,
  input logic [NUM_RANKS-1:0] rank_ready,
  input logic                 mem_off
);
  p_hold_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_mask)));

  p_refresh_awake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1) |-> (cke == {NUM_RANKS{1'b1}}));

  p_off_no_cke_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_off |-> (cke == '0));

  p_exit_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |-> (rank_ready == '0));

  p_close_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0) |-> ((cke & cmd_mask) == cmd_mask));
endmodule

bind rank_pwr_ctrl rpc_checks #(.NUM_RANKS(NUM_RANKS)) u_checks (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_mask(cmd_mask), .cke(cke), .rank_ready(rank_ready),
  .mem_off(mem_off)
);

// File: tb/rank_pwr_ctrl_test.sv
`timescale 1ns/1ps
module rank_pwr_ctrl_test;
  localparam int N = 2;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] pkg_state = 3'd0;
  logic [W-1:0] idle_limit = 8'd4;
  logic cfg_ext_gfx = 1'b1, gfx_idle = 1'b1, disp_pending = 1'b0, cfg_pre_pd = 1'b0;
  logic [N-1:0] rank_pending = '0;
  logic refresh_req = 1'b0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [N-1:0] cmd_mask, cke, rank_ready;
  logic refresh_fire, mem_off;

  always #2.5 clk = ~clk;

  rank_pwr_ctrl #(.NUM_RANKS(N), .CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .pkg_state(pkg_state), .idle_limit(idle_limit),
    .cfg_ext_gfx(cfg_ext_gfx), .gfx_idle(gfx_idle), .disp_pending(disp_pending),
    .cfg_pre_pd(cfg_pre_pd), .rank_pending(rank_pending), .refresh_req(refresh_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_mask(cmd_mask),
    .cke(cke), .rank_ready(rank_ready), .refresh_fire(refresh_fire), .mem_off(mem_off)
  );

  typedef struct packed { logic [1:0] op; logic [N-1:0] mask; } exp_t;
  exp_t exp_q[$];
  int n_vec = 0, n_bad = 0, ack_delay = 0, wait_cnt = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_cmd(input logic [1:0] op, input logic [N-1:0] mask);
    exp_t e;
    e.op = op; e.mask = mask;
    exp_q.push_back(e);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor and acknowledging issuer; each handshake is popped and compared
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_ready) cmd_ready = 1'b0;
      else if (cmd_valid) begin
        if (wait_cnt >= ack_delay) begin
          if (exp_q.size() == 0) check(0, "R11 unexpected command", {28'd0, cmd_op, cmd_mask}, 32'd0);
          else begin
            exp_t e;
            e = exp_q.pop_front();
            check({cmd_op, cmd_mask} == e, "R11 command op/mask", {28'd0, cmd_op, cmd_mask}, {28'd0, e});
          end
          cmd_ready = 1'b1;
          wait_cnt = 0;
        end else wait_cnt++;
      end
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    check(cke == 2'b11 && !cmd_valid && !mem_off, "R1 reset state", {cke, cmd_valid, mem_off}, 32'hC);

    // R2/R7: independent per-rank idle timing, active mode, no command
    rank_pending = 2'b11; cycles(3);
    rank_pending = 2'b10; cycles(4);
    check(cke == 2'b11, "R2 before limit", cke, 2'b11);
    cycles(1);
    check(cke == 2'b10, "R2 rank0 asleep, R7 no command", cke, 2'b10);
    rank_pending = 2'b00; cycles(5);
    check(cke == 2'b00, "R2 rank1 asleep", cke, 2'b00);
    // R3 wake
    rank_pending = 2'b01; cycles(1);
    check(cke == 2'b01, "R3 wake next edge", cke, 2'b01);
    check(rank_ready == 2'b01, "R10 ready follows cke", rank_ready, 2'b01);
    // R2 programmable limit
    idle_limit = 8'd2; rank_pending = 2'b00; cycles(2);
    check(cke == 2'b01, "R2 limit=2 before", cke, 2'b01);
    cycles(1);
    check(cke == 2'b00, "R2 limit=2 after", cke, 2'b00);

    // R9 refresh
    ack_delay = 2;
    expect_cmd(2'd1, 2'b11);
    refresh_req = 1'b1; cycles(1);
    check(cke == 2'b11 && rank_ready == 2'b00, "R9 all awake for refresh", {cke, rank_ready}, 4'hC);
    for (int i = 0; i < 20 && !refresh_fire; i++) @(negedge clk);
    check(refresh_fire == 1'b1, "R9 refresh strobe", refresh_fire, 1);
    check(cke == 2'b00, "R9 asleep after refresh", cke, 2'b00);
    refresh_req = 1'b0; cycles(1);
    check(refresh_fire == 1'b0, "R9 strobe one cycle", refresh_fire, 0);

    // R8 precharge power-down
    rank_pending = 2'b11; cycles(2);
    cfg_pre_pd = 1'b1; ack_delay = 3;
    expect_cmd(2'd0, 2'b11);
    rank_pending = 2'b00; cycles(4);
    check(cmd_valid && cke == 2'b11, "R8 cke held until close ack", {cmd_valid, cke}, 3'h7);
    for (int i = 0; i < 20 && cke != 2'b00; i++) @(negedge clk);
    check(cke == 2'b00 && exp_q.size() == 0, "R8 asleep after close", cke, 2'b00);
    cfg_pre_pd = 1'b0; cycles(2);

    // R4 external graphics
    ack_delay = 1;
    cfg_ext_gfx = 1'b1; rank_pending = 2'b01; pkg_state = 3'd3; cycles(5);
    check(!cmd_valid && cke == 2'b01, "R4 request blocks self-refresh", {cmd_valid, cke}, 3'h1);
    expect_cmd(2'd2, 2'b11);
    rank_pending = 2'b00; cycles(8);
    check(cke == 2'b00 && exp_q.size() == 0, "R4 self-refresh entered", cke, 0);
    ack_delay = 2;
    expect_cmd(2'd3, 2'b11);
    rank_pending = 2'b10;
    for (int i = 0; i < 20 && !cmd_valid; i++) @(negedge clk);
    check(cmd_valid && rank_ready == 2'b00, "R10 no ready before exit ack", rank_ready, 0);
    for (int i = 0; i < 20 && rank_ready == 2'b00; i++) @(negedge clk);
    check(rank_ready == 2'b11, "R10 ready after exit ack", rank_ready, 2'b11);
    pkg_state = 3'd0; cycles(1);
    rank_pending = 2'b00; cycles(4);

    // R5 integrated graphics
    cfg_ext_gfx = 1'b0; gfx_idle = 1'b0; disp_pending = 1'b0; pkg_state = 3'd4; cycles(6);
    check(!cmd_valid && exp_q.size() == 0, "R5 busy graphics blocks", cmd_valid, 0);
    gfx_idle = 1'b1; disp_pending = 1'b1; cycles(6);
    check(!cmd_valid && exp_q.size() == 0, "R5 display pending blocks", cmd_valid, 0);
    ack_delay = 1;
    expect_cmd(2'd2, 2'b11);
    rank_pending = 2'b01; disp_pending = 1'b0; cycles(8);
    check(cke == 2'b00 && exp_q.size() == 0, "R5 enters despite rank request", cke, 0);

    // R6 suspend and off
    pkg_state = 3'd6; gfx_idle = 1'b0; cycles(5);
    check(cke == 2'b00 && !cmd_valid, "R6 S3 holds self-refresh", {cke, cmd_valid}, 0);
    pkg_state = 3'd7; cycles(1);
    check(mem_off && cke == 2'b00, "R6 off", {mem_off, cke}, 3'h4);
    pkg_state = 3'd0; cycles(1);
    check(!mem_off && cke == 2'b11, "R6 leave off", {mem_off, cke}, 3'h3);
    rank_pending = 2'b00; gfx_idle = 1'b1; cycles(6);

    // R12 package change during stalled handshake
    cfg_ext_gfx = 1'b1; ack_delay = 5;
    expect_cmd(2'd2, 2'b11);
    expect_cmd(2'd3, 2'b11);
    pkg_state = 3'd5;
    for (int i = 0; i < 20 && !cmd_valid; i++) @(negedge clk);
    pkg_state = 3'd0;
    cycles(3);
    check(cmd_valid && cmd_op == 2'd2, "R12 entry not aborted", {cmd_valid, cmd_op}, 3'h6);
    for (int i = 0; i < 40 && !(rank_ready == 2'b11 && exp_q.size() == 0); i++) @(negedge clk);
    check(rank_ready == 2'b11 && exp_q.size() == 0, "R12 exit after ack", rank_ready, 2'b11);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    if (!done) check(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule